// File: doc/BRIEF.md
# Register-File Arithmetic/Logic Execute Unit

This block keeps a bank of thirty-two 32-bit general registers and carries out one arithmetic or logic instruction for each cycle in which its start strobe is high. It splits the 32-bit instruction word into an opcode, a target register, two source registers and a 17-bit immediate. It reads the sources, forms the result and writes the result into the target register on the same clock edge that samples the strobe. A completion pulse and an error flag follow one cycle later.

The unit also forms displacement addresses for the load-address instruction. In that case a zero base-register field means a literal zero base, not the contents of register 0. A separate combinational debug port lets the surrounding logic or a bench read any register at any time. Memory access, fetch sequencing, shifts and branches belong to other blocks.

Top module: `rfx_exec_unit`

## Requirements
- R1: Instruction fields are opcode = bits 31..27, target ra = bits 26..22, first source rb = bits 21..17, second source rc = bits 16..12, and immediate c2 = bits 16..0. Register-to-register opcodes use R[0] like any other register, and ra = 0 is a writable target.
- R2: Opcode 12 writes R[rb]+R[rc], opcode 14 writes R[rb]-R[rc] and opcode 15 writes -R[rc]. All arithmetic wraps modulo 2^32.
- R3: Opcodes 13, 21 and 23 combine R[rb] with c2 sign-extended from bit 16, using add, bitwise AND and bitwise OR respectively.
- R4: Opcode 20 writes R[rb] AND R[rc], opcode 22 writes R[rb] OR R[rc] and opcode 24 writes the bitwise complement of R[rc].
- R5: Opcode 5 writes the displacement address into R[ra]. The address is sign-extended c2 when rb = 0, and R[rb] + sign-extended c2 otherwise.
- R6: Opcode 0 changes no register, and it completes with done high and error low.
- R7: The write happens on the rising edge that samples start high. done is high for exactly the one cycle after that edge, and low when start was low on the previous edge.
- R8: Any opcode other than 0, 5, 12-15 and 20-24 completes with done and the error flag both high, and writes no register.
- R9: Synchronous active-high reset clears all 32 registers to zero and holds done and the error flag low.
- R10: The debug port returns R[dbg_addr] combinationally. During the cycle of a write to that register it shows the old value, and from the next cycle on it shows the new value.
- R11: Starts on consecutive cycles execute in order, and the second instruction reads the result the first one wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Execute the instruction on instr_i at this edge |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Debug read register index |
| dbg_data_o | output | 32 | Contents of the register selected by dbg_addr_i |
| done_o | output | 1 | One-cycle completion pulse |
| bad_op_o | output | 1 | Unsupported opcode flag, valid with done_o |

## Verification
Two things can land in the same cycle: a write-back to a register and a debug read of that same register. The bench provokes this by holding start for an instruction that targets the register the debug port is watching. It judges the case by sampling the port before the edge, where the old value is expected, and after the edge, where the new value is expected. A dependent instruction that follows on the very next cycle creates a second overlap, between an operand read and the previous write. The bench checks that the second result is built on the first one.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OPC_W  = 5;
    localparam int IMM_W  = 17;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 5'd0,
        OP_LDA  = 5'd5,
        OP_ADD  = 5'd12,
        OP_ADDI = 5'd13,
        OP_SUB  = 5'd14,
        OP_NEG  = 5'd15,
        OP_AND  = 5'd20,
        OP_ANDI = 5'd21,
        OP_OR   = 5'd22,
        OP_ORI  = 5'd23,
        OP_NOT  = 5'd24
    } opc_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] rc;
        logic [XLEN-1:0]   imm;
        logic              known;
        logic              writes;
    } dec_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] c);
        return {{(XLEN-IMM_W){c[IMM_W-1]}}, c};
    endfunction

    function automatic logic op_known(input logic [OPC_W-1:0] op);
        case (op)
            OP_NOP, OP_LDA, OP_ADD, OP_ADDI, OP_SUB, OP_NEG,
            OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_NOT: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);

    always_comb begin
        dec_o.opc    = instr_i[31:27];
        dec_o.ra     = instr_i[26:22];
        dec_o.rb     = instr_i[21:17];
        dec_o.rc     = instr_i[16:12];
        dec_o.imm    = sext_imm(instr_i[16:0]);
        dec_o.known  = op_known(instr_i[31:27]);
        dec_o.writes = op_known(instr_i[31:27]) && (instr_i[31:27] != OP_NOP);
    end

endmodule

// File: rtl/rfx_alu.sv
module rfx_alu
    import rfx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPC_W-1:0] opc_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [W-1:0]     imm_i,
    input  logic             base_zero_i,
    output logic [W-1:0]     res_o
);

    logic [W-1:0] base;

    always_comb begin
        base = base_zero_i ? '0 : a_i;
        case (opc_i)
            OP_LDA:  res_o = base + imm_i;
            OP_ADD:  res_o = a_i + b_i;
            OP_ADDI: res_o = a_i + imm_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_NEG:  res_o = '0 - b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_ANDI: res_o = a_i & imm_i;
            OP_OR:   res_o = a_i | b_i;
            OP_ORI:  res_o = a_i | imm_i;
            OP_NOT:  res_o = ~b_i;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (opc_i == OP_NEG) begin
            AST_NEG_CANCELS: assert (W'(res_o + b_i) == '0); // R2
        end
        if (opc_i == OP_SUB) begin
            AST_SUB_RESTORES: assert (W'(res_o + b_i) == a_i); // R2
        end
        if (opc_i == OP_NOT) begin
            AST_NOT_DISJOINT: assert ((res_o & b_i) == '0); // R4
        end
    end

endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile
    import rfx_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREG,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] ra_addr_i,
    output logic [W-1:0]  ra_data_o,
    input  logic [AW-1:0] rb_addr_i,
    output logic [W-1:0]  rb_data_o,
    input  logic [AW-1:0] dbg_addr_i,
    output logic [W-1:0]  dbg_data_o
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we_i && (waddr_i == AW'(g))) begin
                regs[g] <= wdata_i;
            end
        end
    end

    assign ra_data_o  = regs[ra_addr_i];
    assign rb_data_o  = regs[rb_addr_i];
    assign dbg_data_o = regs[dbg_addr_i];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dbg_data_o == '0)); // R9

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we_i) && $stable(dbg_addr_i)) |-> $stable(dbg_data_o)); // R6

endmodule

// File: rtl/rfx_exec_unit.sv
module rfx_exec_unit
    import rfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [RIDX_W-1:0] dbg_addr_i,
    output logic [XLEN-1:0]   dbg_data_o,
    output logic              done_o,
    output logic              bad_op_o
);

    dec_t            dec;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] result;
    logic            wr_en;
    logic            done_q;
    logic            bad_q;

    rfx_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    rfx_regfile #(.W(XLEN), .N(NREG), .AW(RIDX_W)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .we_i       (wr_en),
        .waddr_i    (dec.ra),
        .wdata_i    (result),
        .ra_addr_i  (dec.rb),
        .ra_data_o  (opa),
        .rb_addr_i  (dec.rc),
        .rb_data_o  (opb),
        .dbg_addr_i (dbg_addr_i),
        .dbg_data_o (dbg_data_o)
    );

    rfx_alu #(.W(XLEN)) u_alu (
        .opc_i       (dec.opc),
        .a_i         (opa),
        .b_i         (opb),
        .imm_i       (dec.imm),
        .base_zero_i (dec.rb == '0),
        .res_o       (result)
    );

    assign wr_en = start_i && dec.writes && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            done_q <= start_i;
            bad_q  <= start_i && !dec.known;
        end
    end

    assign done_o   = done_q;
    assign bad_op_o = bad_q;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o); // R7

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i)); // R7

    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (start_i && !op_known(instr_i[31:27])) |-> !wr_en); // R8

    AST_BAD_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        bad_op_o |-> done_o); // R8

    AST_WRITE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> start_i); // R7

endmodule

// File: tb/rfx_exec_unit_test.sv
module rfx_exec_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [4:0]  dbg_addr_i = '0;
    logic [31:0] dbg_data_o;
    logic        done_o;
    logic        bad_op_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfx_exec_unit uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .instr_i    (instr_i),
        .dbg_addr_i (dbg_addr_i),
        .dbg_data_o (dbg_data_o),
        .done_o     (done_o),
        .bad_op_o   (bad_op_o)
    );

    function automatic logic [31:0] enc(input int op, input int ra, input int rb, input logic [16:0] c);
        return {op[4:0], ra[4:0], rb[4:0], c};
    endfunction

    function automatic logic [31:0] encr(input int op, input int ra, input int rb, input int rc);
        return enc(op, ra, rb, {rc[4:0], 12'h000});
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{enc(5, 1, 0, 17'h00123),  32'h0000_0123},  // R5 zero base
        '{enc(5, 2, 0, 17'h1FFFE),  32'hFFFF_FFFE},  // R5 negative imm
        '{encr(12, 3, 1, 2),        32'h0000_0121},  // R2 add
        '{encr(14, 4, 2, 1),        32'hFFFF_FEDB},  // R2 sub
        '{encr(15, 5, 0, 1),        32'hFFFF_FEDD},  // R2 neg
        '{enc(13, 6, 1, 17'h10000), 32'hFFFF_0123},  // R3 addi
        '{encr(20, 7, 6, 4),        32'hFFFF_0003},  // R4 and
        '{encr(22, 8, 1, 5),        32'hFFFF_FFFF},  // R4 or
        '{encr(24, 9, 0, 1),        32'hFFFF_FEDC},  // R4 not
        '{enc(21, 10, 2, 17'h0F0F0),32'h0000_F0F0},  // R3 andi
        '{enc(23, 11, 1, 17'h18000),32'hFFFF_8123},  // R3 ori
        '{enc(5, 12, 1, 17'h1FFFF), 32'h0000_0122},  // R5 register base
        '{encr(12, 13, 8, 8),       32'hFFFF_FFFE},  // R2 wrap
        '{encr(12, 0, 1, 1),        32'h0000_0246},  // R1 ra=0 writable
        '{enc(5, 15, 0, 17'h00005), 32'h0000_0005},  // R5 rb=0 ignores R[0]
        '{encr(12, 16, 0, 1),       32'h0000_0369}   // R1 reg op reads R[0]
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins);
        @(negedge clk);
        start_i = 1'b1;
        instr_i = ins;
        @(negedge clk);
        start_i = 1'b0;
        instr_i = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R7 watchdog act=timeout exp=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 done low", {31'd0, done_o}, 32'd0);
        chk("R9 bad low", {31'd0, bad_op_o}, 32'd0);
        for (int i = 0; i < 32; i++) begin
            dbg_addr_i = 5'(i);
            #1;
            chk("R9 reg clear", dbg_data_o, 32'd0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            run(VECS[v].ins);
            chk("R7 done", {31'd0, done_o}, 32'd1);
            chk("R8 no err", {31'd0, bad_op_o}, 32'd0);
            dbg_addr_i = VECS[v].ins[26:22];
            #1;
            chk($sformatf("R1 vec %0d", v), dbg_data_o, VECS[v].exp);
        end

        // R7 pulse length: done drops one cycle later
        @(negedge clk);
        chk("R7 done single", {31'd0, done_o}, 32'd0);

        // R6 nop: no register change
        run(enc(0, 1, 2, 17'h00777));
        chk("R6 done", {31'd0, done_o}, 32'd1);
        chk("R6 no err", {31'd0, bad_op_o}, 32'd0);
        dbg_addr_i = 5'd1;
        #1;
        chk("R6 r1 kept", dbg_data_o, 32'h0000_0123);

        // R8 unsupported opcodes
        run(enc(1, 1, 0, 17'h00055));
        chk("R8 done", {31'd0, done_o}, 32'd1);
        chk("R8 err", {31'd0, bad_op_o}, 32'd1);
        dbg_addr_i = 5'd1;
        #1;
        chk("R8 r1 kept", dbg_data_o, 32'h0000_0123);
        run(encr(31, 3, 1, 1));
        chk("R8 err op31", {31'd0, bad_op_o}, 32'd1);
        dbg_addr_i = 5'd3;
        #1;
        chk("R8 r3 kept", dbg_data_o, 32'h0000_0121);
        @(negedge clk);
        chk("R8 err clears", {31'd0, bad_op_o}, 32'd0);

        // R10 debug read during the write cycle
        dbg_addr_i = 5'd17;
        @(negedge clk);
        start_i = 1'b1;
        instr_i = enc(5, 17, 0, 17'h0ABCD);
        #1;
        chk("R10 old value", dbg_data_o, 32'd0);
        chk("R7 done before edge", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 new value", dbg_data_o, 32'h0000_ABCD);

        // R11 back-to-back dependent starts
        @(negedge clk);
        start_i = 1'b1;
        instr_i = enc(5, 18, 0, 17'h00007);
        @(negedge clk);
        instr_i = encr(12, 19, 18, 18);
        chk("R11 done first", {31'd0, done_o}, 32'd1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 done second", {31'd0, done_o}, 32'd1);
        dbg_addr_i = 5'd19;
        #1;
        chk("R11 dependent", dbg_data_o, 32'h0000_000E);

        // R9 second reset clears written registers
        do_reset();
        dbg_addr_i = 5'd19;
        #1;
        chk("R9 r19 cleared", dbg_data_o, 32'd0);
        dbg_addr_i = 5'd0;
        #1;
        chk("R9 r0 cleared", dbg_data_o, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule